// File: doc/BRIEF.md
# Masked Interrupt Controller

This block gathers up to 32 interrupt lines for a small processor core and raises a single request to it. A mask register selects which lines may interrupt. A status register records which lines are pending. Software reaches both through a narrow special-register port, and the port reads back combinationally from the registered state. A build-time parameter makes every line edge triggered or level triggered. Another parameter makes the two lowest lines permanently unmaskable, and a third removes the controller from the path entirely (bypass).

The request is held back until the core signals an instruction boundary on a strobe input. It is gated by the core's global interrupt-enable flag. Once raised, the request drops as soon as its condition goes away. Any rising interrupt input also produces a one-cycle wake pulse, which the power-management logic uses to clear its doze and sleep enables.

Top module: `irqc_top`

## Requirements
- R1: After reset the status register reads 0, the request and wake outputs are 0, and the mask register reads 0x00000003 when the unmaskable option is on and 0x00000000 when it is off.
- R2: In edge mode, a 0-to-1 change on a line, detected against a registered copy of the inputs, sets that status bit one clock later. A line held high sets nothing further. A new assertion on a line whose status bit is already set leaves the bit unchanged.
- R3: In edge mode, a write to the status address (address 1) clears every status bit whose write-data bit is 0 and keeps those written 1. A new edge on a line in the same cycle as a clear of that line leaves the bit set.
- R4: In level mode, each status bit shows the state of its input as registered one clock earlier. Writes to the status address have no effect, so only lowering the input clears a pending line.
- R5: A write to the mask address (address 0) loads the mask from the write data. With the unmaskable option on, bits 1 and 0 stay 1 whatever is written.
- R6: The request output rises only at a clock edge where the boundary strobe is 1, the global enable is 1 and mask AND status is nonzero. It stays high while the global enable is 1 and mask AND status is nonzero, and falls at the first edge where either condition is false.
- R7: A pending line that was masked, or that was held off by a cleared global enable, raises the request one clock after the mask write or the enable change that unblocks it, provided the boundary strobe is high at that edge.
- R8: In every mode, the wake output is 1 for the cycle after any input line goes from 0 to 1, and it returns to 0 when no line rose.
- R9: In bypass mode, mask and status keep their reset values and register writes are ignored. The request follows the OR of the raw input lines, gated by the global enable and taken at a boundary strobe.
- R10: Reads decode address 0 as the mask, 1 as the status, 2 as the presence word (bit 0 = 1 when the controller is active, 0 in bypass) and 3 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Interrupt input lines |
| gie_i | input | 1 | Core global interrupt-enable flag |
| insn_done_i | input | 1 | Instruction-boundary strobe from the core |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the current address |
| irq_req_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle pulse that clears doze and sleep enables |

## Verification
The assertions assume that the interrupt lines, the register port and the core flags are synchronous to the clock and hold steady across each rising edge. They also assume that a status bit can fall in edge mode only through a register write. The bench changes every input on the falling edge and samples on the next falling edge, so each rising edge sees stable values. Three instances cover edge mode with unmaskable lines, level mode without them, and bypass. Register writes go to all three instances at once, and each check reads only the instance under test.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ADDR_MASK    = 2'd0,
        ADDR_STATUS  = 2'd1,
        ADDR_PRESENT = 2'd2,
        ADDR_SPARE   = 2'd3
    } irqc_addr_e;

    localparam int unsigned NMI_LINES = 2;

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] irq_i,
    output logic [NUM_LINES-1:0] rise_o,
    output logic                 wake_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic                 wake;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        rise_o       = irq_i & ~cap_q.prev;
        cap_d.prev   = irq_i;
        cap_d.wake   = |rise_o;
        wake_o       = cap_q.wake;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    // R8: a wake pulse is always preceded by some active input
    assert_wake_after_input_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(|irq_i));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter bit          EDGE_TRIG = 1'b1,
    parameter bit          NMI_EN    = 1'b1,
    parameter bit          ENABLED   = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic [NUM_LINES-1:0] rise_i,
    input  logic                 wr_en_i,
    input  irqc_addr_e           addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] status_o,
    output logic [DATA_W-1:0]    rd_data_o
);

    localparam logic [NUM_LINES-1:0] NMI_FORCE = NMI_EN ? NUM_LINES'(2'b11) : '0;
    localparam logic [NUM_LINES-1:0] MASK_RST  = NMI_FORCE;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] status;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  wr_mask, wr_status;
    logic  [NUM_LINES-1:0] status_nxt;

    assign wr_mask   = wr_en_i && (addr_i == ADDR_MASK);
    assign wr_status = wr_en_i && (addr_i == ADDR_STATUS);

    if (EDGE_TRIG) begin : g_edge
        // software clear first, new edge wins over it
        assign status_nxt = (wr_status ? (reg_q.status & wr_data_i[NUM_LINES-1:0])
                                       : reg_q.status) | rise_i;
    end else begin : g_level
        assign status_nxt = irq_i;
    end

    always_comb begin
        reg_d = reg_q;
        if (ENABLED) begin
            if (wr_mask) reg_d.mask = wr_data_i[NUM_LINES-1:0] | NMI_FORCE;
            reg_d.status = status_nxt;
        end
        unique case (addr_i)
            ADDR_MASK:    rd_data_o = DATA_W'(reg_q.mask);
            ADDR_STATUS:  rd_data_o = DATA_W'(reg_q.status);
            ADDR_PRESENT: rd_data_o = DATA_W'(ENABLED ? 1 : 0);
            default:      rd_data_o = '0;
        endcase
        mask_o   = reg_q.mask;
        status_o = reg_q.status;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) reg_q <= '{mask: MASK_RST, status: '0};
        else         reg_q <= reg_d;
    end

    if (NMI_EN) begin : g_nmi_chk
        // R5: unmaskable bits survive any mask write
        assert_nmi_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_mask |=> (mask_o[1:0] == 2'b11));
    end

    if (ENABLED) begin : g_on_chk
        // R2: a status bit only sets when its line was high
        assert_set_needs_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |-> ((status_o & ~$past(status_o) & ~$past(irq_i)) == '0));
        if (EDGE_TRIG) begin : g_edge_chk
            // R3: in edge mode a bit falls only through a status write
            assert_clear_needs_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (|($past(status_o) & ~status_o)) |-> $past(wr_status));
        end
    end else begin : g_off_chk
        // R9: bypass keeps the mask at its reset value after a write
        assert_bypass_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_mask |=> (mask_o == MASK_RST));
    end

endmodule

// File: rtl/irqc_req.sv
module irqc_req (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_any_i,
    input  logic gie_i,
    input  logic insn_done_i,
    output logic req_o
);

    typedef struct packed {
        logic req;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        // rises only at a boundary, falls as soon as its cause is gone
        req_d.req = pend_any_i && gie_i && (insn_done_i || req_q.req);
        req_o     = req_q.req;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
    end

    // R6: request rises only on a boundary strobe
    assert_req_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_o) |-> $past(insn_done_i));

    // R6: request is always backed by enable and a pending line
    assert_req_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> $past(gie_i && pend_any_i));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter bit          EDGE_TRIG = 1'b1,
    parameter bit          NMI_EN    = 1'b1,
    parameter bit          ENABLED   = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 gie_i,
    input  logic                 insn_done_i,
    input  logic                 reg_wr_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_req_o,
    output logic                 wake_o
);

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] status;
    logic                 pend_any;

    irqc_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .rise_o (rise),
        .wake_o (wake_o)
    );

    irqc_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .EDGE_TRIG (EDGE_TRIG),
        .NMI_EN    (NMI_EN),
        .ENABLED   (ENABLED)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .irq_i     (irq_i),
        .rise_i    (rise),
        .wr_en_i   (reg_wr_i),
        .addr_i    (irqc_addr_e'(reg_addr_i)),
        .wr_data_i (reg_wdata_i),
        .mask_o    (mask),
        .status_o  (status),
        .rd_data_o (reg_rdata_o)
    );

    if (ENABLED) begin : g_active
        assign pend_any = |(mask & status);
    end else begin : g_bypass
        assign pend_any = |irq_i;
    end

    irqc_req u_req (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pend_any_i  (pend_any),
        .gie_i       (gie_i),
        .insn_done_i (insn_done_i),
        .req_o       (irq_req_o)
    );

endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gie = 1'b0, done = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] irq_e = '0, irq_l = '0, irq_b = '0;
    logic [31:0] rd_e, rd_l, rd_b;
    logic        req_e, req_l, req_b, wake_e, wake_l, wake_b;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    irqc_top #(.EDGE_TRIG(1), .NMI_EN(1), .ENABLED(1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_e), .gie_i(gie), .insn_done_i(done),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_e),
        .irq_req_o(req_e), .wake_o(wake_e));

    irqc_top #(.EDGE_TRIG(0), .NMI_EN(0), .ENABLED(1)) dut_lvl (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_l), .gie_i(gie), .insn_done_i(done),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_l),
        .irq_req_o(req_l), .wake_o(wake_l));

    irqc_top #(.EDGE_TRIG(1), .NMI_EN(0), .ENABLED(0)) dut_byp (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_b), .gie_i(gie), .insn_done_i(done),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_b),
        .irq_req_o(req_b), .wake_o(wake_b));

    // vector: irq, write enable, address, write data, expected read at address
    typedef struct packed {
        logic [31:0] irq;
        logic        we;
        logic [1:0]  ad;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        {32'h0000_0010, 1'b0, 2'd1, 32'h0000_0000, 32'h0000_0010}, // R2 edge sets
        {32'h0000_0010, 1'b0, 2'd1, 32'h0000_0000, 32'h0000_0010}, // R2 held line
        {32'h0000_0000, 1'b1, 2'd1, 32'hFFFF_FFEF, 32'h0000_0000}, // R3 zero clears
        {32'h0000_0100, 1'b1, 2'd1, 32'h0000_0000, 32'h0000_0100}, // R3 edge wins
        {32'h0000_0000, 1'b1, 2'd0, 32'h0000_0100, 32'h0000_0103}, // R5 mask load
        {32'h0000_0000, 1'b1, 2'd0, 32'h0000_0000, 32'h0000_0003}, // R5 nmi kept
        {32'h8000_0001, 1'b0, 2'd1, 32'h0000_0000, 32'h8000_0101}, // R2 two lines
        {32'h8000_0001, 1'b1, 2'd1, 32'h0000_0000, 32'h0000_0000}  // R3 clear all
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        addr = 2'd0; #1;
        chk("R1 mask nmi", rd_e, 32'h3);
        chk("R1 mask plain", rd_l, 32'h0);
        chk("R1 mask bypass", rd_b, 32'h0);
        addr = 2'd1; #1;
        chk("R1 status", rd_e, 32'h0);
        chk("R1 req", {31'd0, req_e}, 32'h0);
        chk("R1 wake", {31'd0, wake_e}, 32'h0);
        addr = 2'd2; #1;
        chk("R10 present on", rd_e, 32'h1);
        chk("R10 present bypass", rd_b, 32'h0);
        addr = 2'd3; #1;
        chk("R10 spare", rd_e, 32'h0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            irq_e = VEC[i].irq; wr = VEC[i].we; addr = VEC[i].ad; wdata = VEC[i].wd;
            tick();
            chk($sformatf("R2/R3/R5 vector %0d", i), rd_e, VEC[i].exp);
        end
        wr = 1'b0;

        // R8 wake pulse and R2 ignore-while-pending
        irq_e = 32'h8000_0003; tick();
        chk("R8 wake high", {31'd0, wake_e}, 32'h1);
        tick();
        chk("R8 wake low", {31'd0, wake_e}, 32'h0);
        irq_e = 32'h8000_0001; tick();
        irq_e = 32'h8000_0003; tick();
        addr = 2'd1; #1;
        chk("R2 pending ignored", rd_e, 32'h2);
        wreg(2'd1, 32'h0);
        irq_e = 32'h0; tick();

        // R6 boundary strobe and drop
        irq_e = 32'h100; tick();
        gie = 1'b1;
        wreg(2'd0, 32'h100);
        tick();
        chk("R6 no strobe", {31'd0, req_e}, 32'h0);
        done = 1'b1; tick();
        chk("R6 rise at strobe", {31'd0, req_e}, 32'h1);
        done = 1'b0; tick();
        chk("R6 holds", {31'd0, req_e}, 32'h1);
        wreg(2'd1, 32'h0);
        tick();
        chk("R6 drops", {31'd0, req_e}, 32'h0);

        // R7 re-evaluation on mask write and enable
        irq_e = 32'h0; tick();
        irq_e = 32'h100; tick();
        wreg(2'd0, 32'h0);
        done = 1'b1; tick();
        chk("R7 masked", {31'd0, req_e}, 32'h0);
        wreg(2'd0, 32'h100);
        tick();
        chk("R7 after mask write", {31'd0, req_e}, 32'h1);
        gie = 1'b0; tick();
        chk("R7 enable off", {31'd0, req_e}, 32'h0);
        gie = 1'b1; tick();
        chk("R7 enable on", {31'd0, req_e}, 32'h1);
        done = 1'b0; gie = 1'b0;
        wreg(2'd1, 32'h0);
        irq_e = 32'h0;

        // R4 level mode
        irq_l = 32'h20; tick();
        addr = 2'd1; #1;
        chk("R4 follows input", rd_l, 32'h20);
        chk("R8 wake level", {31'd0, wake_l}, 32'h1);
        wreg(2'd1, 32'h0);
        chk("R4 write ignored", rd_l, 32'h20);
        irq_l = 32'h0; tick();
        chk("R4 clears on low", rd_l, 32'h0);

        // R9 bypass
        wreg(2'd0, 32'hFF);
        chk("R9 mask write ignored", rd_b, 32'h0);
        irq_b = 32'h4; gie = 1'b1; done = 1'b1; tick();
        addr = 2'd1; #1;
        chk("R9 status stays zero", rd_b, 32'h0);
        chk("R9 raw request", {31'd0, req_b}, 32'h1);
        chk("R8 wake bypass", {31'd0, wake_b}, 32'h1);
        irq_b = 32'h0; tick();
        chk("R9 request follows line", {31'd0, req_b}, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule